// File: doc/BRIEF.md
# Dual-Edge Input Capture Unit

This unit timestamps both transitions of an asynchronous capture pin against an internal 8-bit free-running counter. The pin is brought into the clock domain through a two-stage synchronizer. A transition is recognised by comparing the newest synchronized sample with the one before it. Every low-to-high transition stores the counter in a rise register, and every high-to-low transition stores it in a fall register. Software can therefore measure pulse widths and periods from the two stamps.

A single edge-polarity bit does not gate the captures. It only decides which of the two transitions sets a sticky interrupt flag. An enable bit passes that flag out as an interrupt request. Software reads both stamps, the control bits and the live counter through a small read port. The only things it can write are the two control bits and a clear of the flag.

Top module: `dual_edge_capture`

## Requirements
- R1: After reset the rise stamp, fall stamp, counter, polarity bit, enable bit, flag and `irq` are all zero.
- R2: The counter reads at address 3. Each clock with `cnt_en`=1 adds one to it, wrapping from 0xFF to 0x00. With `cnt_en`=0 it holds its value.
- R3: A low-to-high change on `cap_in` loads the rise stamp (read at address 1) with the counter value that was current in the clock before the third rising clock edge after the change.
- R4: A high-to-low change on `cap_in` loads the fall stamp (read at address 0) with the counter value under the same timing as R3.
- R5: Each stamp is loaded on every transition of its own polarity, whatever the polarity bit holds. A transition of the other polarity leaves the stamp unchanged.
- R6: The flag is control bit 2. When the polarity bit (control bit 0) is 1, only falling transitions set the flag. When it is 0, only rising transitions set it.
- R7: `irq` is high exactly when the flag is set and the enable bit (control bit 1) is 1.
- R8: Writing to address 2 loads bits 0 and 1 from `wr_data[0]` and `wr_data[1]`. When `wr_data[2]`=0 the write also clears the flag, and when `wr_data[2]`=1 it leaves the flag alone. If a flag-setting capture lands on the same clock as a clearing write, the flag ends up set.
- R9: Writes to addresses 0, 1 and 3 change nothing.
- R10: A pulse on `cap_in` lasting two clocks, high or low, produces a correct stamp for both of its transitions.
- R11: Reading address 2 returns the polarity bit at bit 0, the enable bit at bit 1, the flag at bit 2, and zeros in bits 7 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | 1 | Asynchronous capture pin |
| cnt_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 3 | Write data (control bits and flag clear) |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every combination of the polarity and enable bits against rising and falling transitions at several counter positions. A design that loaded only the selected edge's stamp, or raised the flag on the wrong polarity, fails there at once. It lands a clearing write on the same clock as a flag-setting capture, which catches a design that lets the clear win. It applies two-clock pulses of both polarities, which catch an edge detector that loses closely spaced transitions. It also runs the counter across its wrap and writes to the read-only addresses, which expose an overflow off by one and stamps that the bus can overwrite.

// File: rtl/dual_edge_capture.sv
module dual_edge_capture #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int CTRL_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_in,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(3);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CNT_W-1:0]       cnt, cap_rise, cap_fall;
  logic                   edge_sel, irq_en, flag;

  wire level     = sync_q[SYNC_STAGES-1];
  wire rise_det  = level & ~prev_q;
  wire fall_det  = ~level & prev_q;
  wire ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  wire set_flag  = (rise_det & ~edge_sel) | (fall_det & edge_sel);
  wire clr_flag  = ctrl_wr & ~wr_data[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cap_in};
      prev_q <= level;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_rise <= '0;
      cap_fall <= '0;
    end else begin
      if (rise_det) cap_rise <= cnt;
      if (fall_det) cap_fall <= cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_sel <= 1'b0;
      irq_en   <= 1'b0;
      flag     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        edge_sel <= wr_data[0];
        irq_en   <= wr_data[1];
      end
      flag <= set_flag | (flag & ~clr_flag);
    end
  end

  assign irq = flag & irq_en;

  always_comb begin
    unique case (rd_addr)
      A_FALL:  rd_data = cap_fall;
      A_RISE:  rd_data = cap_rise;
      A_CTRL:  rd_data = {{(CNT_W-3){1'b0}}, flag, irq_en, edge_sel};
      A_CNT:   rd_data = cnt;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dual_edge_capture_chk.sv
module dual_edge_capture_chk #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 2,
  parameter int CTRL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic [CNT_W-1:0]  cnt,
  input logic              rise_det,
  input logic              fall_det,
  input logic              edge_sel,
  input logic              flag,
  input logic [CNT_W-1:0]  cap_rise,
  input logic [CNT_W-1:0]  cap_fall,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CTRL_W-1:0] wr_data
);
  wire sel_hit = (rise_det && !edge_sel) || (fall_det && edge_sel);

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cnt == CNT_W'($past(cnt) + 1'b1));
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt));
  p_rise_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_det |=> cap_rise == $past(cnt));
  p_fall_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_det |=> cap_fall == $past(cnt));
  p_rise_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_det |=> $stable(cap_rise));
  p_fall_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_det |=> $stable(cap_fall));
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |=> flag);
  p_flag_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !sel_hit) |=> !flag);
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(2) && !wr_data[2] && !sel_hit) |=> !flag);
endmodule

bind dual_edge_capture dual_edge_capture_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt(cnt),
  .rise_det(rise_det), .fall_det(fall_det), .edge_sel(edge_sel), .flag(flag),
  .cap_rise(cap_rise), .cap_fall(cap_fall),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/dual_edge_capture_tb.sv
module dual_edge_capture_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_in = 1'b0;
  logic       cnt_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [2:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int total = 0;
  int fails = 0;
  bit done  = 0;
  logic [7:0] exp_cnt = '0;

  dual_edge_capture u_dut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .cnt_en(cnt_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n)      exp_cnt <= '0;
    else if (cnt_en) exp_cnt <= exp_cnt + 8'd1;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edge_ev(input logic lvl, input bit clr_same, input logic [2:0] cdata,
                         output logic [7:0] snap);
    cap_in = lvl;
    step(2);
    snap = exp_cnt;
    if (clr_same) begin
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = cdata;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, e, keep, c0;
    step(3);
    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reset reg", v, 8'h00);
    end
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    cnt_en = 1'b1;
    step(5);
    rd(2'd3, v); chk("R2 count", v, exp_cnt);

    // R2 wrap and hold
    rd(2'd3, c0);
    step(int'(8'hFF - c0));
    rd(2'd3, v); chk("R2 at FF", v, 8'hFF);
    step(1);
    rd(2'd3, v); chk("R2 wrap", v, 8'h00);
    cnt_en = 1'b0;
    rd(2'd3, c0);
    step(5);
    rd(2'd3, v); chk("R2 hold", v, c0);
    cnt_en = 1'b1;

    // R3 R4 R5 R6 R7 R11 sweep
    for (int sel = 0; sel < 2; sel++) begin
      for (int en = 0; en < 2; en++) begin
        for (int k = 0; k < 4; k++) begin
          step(k * 37 + 1);
          wr(2'd2, {1'b0, 1'(en), 1'(sel)});
          rd(2'd2, v); chk("R11 ctrl readback", v, {5'b0, 1'b0, 1'(en), 1'(sel)});
          rd(2'd0, keep);
          edge_ev(1'b1, 0, 3'b0, e);
          rd(2'd1, v); chk("R3 rise stamp", v, e);
          rd(2'd0, v); chk("R5 fall stamp kept", v, keep);
          rd(2'd2, v); chk("R6 flag after rise", {7'b0, v[2]}, {7'b0, sel == 0});
          chk("R7 irq after rise", {7'b0, irq}, {7'b0, (sel == 0) && (en == 1)});
          wr(2'd2, {1'b0, 1'(en), 1'(sel)});
          rd(2'd1, keep);
          edge_ev(1'b0, 0, 3'b0, e);
          rd(2'd0, v); chk("R4 fall stamp", v, e);
          rd(2'd1, v); chk("R5 rise stamp kept", v, keep);
          rd(2'd2, v); chk("R6 flag after fall", {7'b0, v[2]}, {7'b0, sel == 1});
          chk("R7 irq after fall", {7'b0, irq}, {7'b0, (sel == 1) && (en == 1)});
        end
      end
    end

    // R8 flag write semantics
    wr(2'd2, 3'b010);
    edge_ev(1'b1, 0, 3'b0, e);
    wr(2'd2, 3'b110);
    rd(2'd2, v); chk("R8 write 1 keeps flag", v, 8'h06);
    chk("R7 irq with flag", {7'b0, irq}, 8'h01);
    wr(2'd2, 3'b010);
    rd(2'd2, v); chk("R8 write 0 clears flag", v, 8'h02);
    chk("R7 irq cleared", {7'b0, irq}, 8'h00);
    cap_in = 1'b0; step(4);
    wr(2'd2, 3'b010);
    edge_ev(1'b1, 1, 3'b010, e);
    rd(2'd2, v); chk("R8 set wins over clear", v, 8'h06);
    rd(2'd1, v); chk("R3 stamp during clear", v, e);

    // R9 read-only addresses
    cnt_en = 1'b0;
    step(1);
    rd(2'd0, keep); rd(2'd1, c0);
    wr(2'd0, 3'b111); wr(2'd1, 3'b101); wr(2'd3, 3'b111);
    rd(2'd0, v); chk("R9 fall stamp unwritable", v, keep);
    rd(2'd1, v); chk("R9 rise stamp unwritable", v, c0);
    rd(2'd3, v); chk("R9 count unwritable", v, exp_cnt);
    cnt_en = 1'b1;

    // R10 two-clock pulses
    cap_in = 1'b0; step(4);
    cap_in = 1'b1; step(2);
    e = exp_cnt; cap_in = 1'b0; step(2);
    c0 = exp_cnt; step(2);
    rd(2'd1, v); chk("R10 high pulse rise", v, e);
    rd(2'd0, v); chk("R10 high pulse fall", v, c0);
    cap_in = 1'b1; step(4);
    cap_in = 1'b0; step(2);
    e = exp_cnt; cap_in = 1'b1; step(2);
    c0 = exp_cnt; step(2);
    rd(2'd0, v); chk("R10 low pulse fall", v, e);
    rd(2'd1, v); chk("R10 low pulse rise", v, c0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule